// File: doc/BRIEF.md
# Pulse-Interval Command Frame Encoder

This block builds the transmit waveform for a reader-to-tag command. A command bit string with its length is loaded together with a checksum choice, a header choice, a symbol-period (Tari) choice and a calibration length, and a start strobe launches the frame. The encoder places a header in front of the data, appends a 5-bit or 16-bit cyclic checksum computed while the data bits go out, and emits the result as an on/off (carrier high / carrier low) sample stream. It produces exactly one sample per quarter symbol period.

Pulse-interval coding tells a zero from a one by the length of the high part of a symbol: every symbol ends with a fixed short low gap. The header is either a short sync (low delimiter, a zero symbol, then a reader calibration symbol) or the long form, which adds a tag calibration symbol whose high length is programmable. The sample clock is a divided copy of the system clock. Its divide ratio doubles with each step of the symbol-period select. A raised-cosine shaper and a DAC follow this block in the transmit chain.

Top module: `pie_frame_encoder`

## Requirements
- R1: During and after reset, `tx_sample` is 1 (carrier on), and `tx_valid` and `tx_done` are 0.
- R2: Let term = QTR_BASE × 1, 2 or 4 for `tari_sel` 0, 1 or 2 (code 3 acts as 2). Sample k (counted from 0) is presented with a one-cycle `tx_valid` pulse term×(k+1) cycles after the clock edge that accepts `start`. `tx_sample` holds its value between pulses.
- R3: Every frame opens with a low delimiter of 8, 4 or 2 samples for `tari_sel` 0, 1 or 2/3.
- R4: A 0 symbol is 2 high then 2 low samples. A 1 symbol is 6 high then 2 low samples. Command bits go out from `cmd_bits[cmd_len-1]` down to `cmd_bits[0]`.
- R5: With `crc_sel`=0, a 5-bit checksum follows the command bits. It uses polynomial x^5+x^3+1 with preset 01001, runs over the command bits in transmit order, and is sent MSB first, not inverted.
- R6: With `crc_sel`=1, a 16-bit checksum follows the command bits. It uses polynomial x^16+x^12+x^5+1 with preset FFFF, and its ones' complement is sent MSB first.
- R7: With `hdr_sel`=0, the header is the delimiter, one 0 symbol, then a reader calibration symbol of 10 high and 2 low samples, followed directly by the payload.
- R8: With `hdr_sel`=1, a tag calibration symbol of `trcal_hi` high samples and 2 low samples is inserted between the reader calibration symbol and the payload.
- R9: After the last payload sample, the low level holds for one further term. Then `tx_done` pulses for one cycle, `tx_sample` returns to 1 on the same edge, and no `tx_valid` pulse is given.
- R10: Between frames `tx_sample` stays 1 and `tx_valid` stays 0.
- R11: All frame inputs are captured on the accepting edge. A `start` pulse or an input change while a frame is running has no effect on that frame.
- R12: A `cmd_len` of 0 sends only the checksum of the preset (01001 for 5-bit, 0000 for 16-bit). A `cmd_len` above MAX_CMD_BITS is treated as MAX_CMD_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_bits | input | MAX_CMD_BITS | Command bits, LSB-aligned, last-sent bit at index 0 |
| cmd_len | input | $clog2(MAX_CMD_BITS+1) | Number of command bits |
| crc_sel | input | 1 | 0: 5-bit checksum, 1: 16-bit checksum |
| hdr_sel | input | 1 | 0: short sync header, 1: long header with tag calibration |
| tari_sel | input | 2 | Symbol period: 0 short, 1 double, 2 and 3 quadruple |
| trcal_hi | input | TRCAL_W | High samples of the tag calibration symbol |
| start | input | 1 | Launch strobe, accepted only while idle |
| tx_sample | output | 1 | On/off sample, 1 = carrier on |
| tx_valid | output | 1 | One-cycle pulse marking each new sample |
| tx_done | output | 1 | One-cycle pulse at frame end |

## Verification
Every result of this block is due a whole number of sample periods after the accepting edge. Sample k appears term×(k+1) cycles later. `tx_done` and the return to carrier-on come term×(N+1) cycles later, where N counts header and payload samples. The bench builds the sample list of each frame from the requirements and derives from it the full expected triple of `tx_sample`, `tx_valid` and `tx_done` for every cycle. It compares that triple on the falling edge after each rising edge, so each check lands in the cycle a result is due and in none other. Idle cycles between frames and a start pulse injected mid-frame are compared the same way.

// File: rtl/pie_enc_pkg.sv
package pie_enc_pkg;

    typedef enum logic [2:0] {
        SEG_DELIM,
        SEG_SYNC0,
        SEG_RTCAL,
        SEG_TRCAL,
        SEG_CMD,
        SEG_CRC,
        SEG_TAIL
    } seg_e;

    localparam int SYM_LO_SAMPLES = 2;
    localparam int ZERO_HI_SAMPLES = 2;
    localparam int ONE_HI_SAMPLES = 6;
    localparam int RTCAL_HI_SAMPLES = 10;
    localparam int CRC5_LEN = 5;
    localparam int CRC16_LEN = 16;
    localparam logic [4:0] CRC5_PRESET = 5'b01001;
    localparam logic [4:0] CRC5_TAPS = 5'b01001;
    localparam logic [15:0] CRC16_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC16_TAPS = 16'h1021;

    // divide exponent: codes 0,1,2 map to x1,x2,x4; code 3 reuses x4
    function automatic logic [1:0] tari_shift(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // a 12.5 us low interval measured in quarter-symbol samples
    function automatic logic [3:0] delim_samples(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd8;
            2'd1:    return 4'd4;
            default: return 4'd2;
        endcase
    endfunction

    function automatic logic [4:0] crc5_next(input logic [4:0] r, input logic b);
        return {r[3:0], 1'b0} ^ ((r[4] ^ b) ? CRC5_TAPS : 5'b0);
    endfunction

    function automatic logic [15:0] crc16_next(input logic [15:0] r, input logic b);
        return {r[14:0], 1'b0} ^ ((r[15] ^ b) ? CRC16_TAPS : 16'b0);
    endfunction

endpackage

// File: rtl/pie_qtick_div.sv
module pie_qtick_div
    import pie_enc_pkg::*;
#(
    parameter int QTR_BASE = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] tari_code,
    output logic       tick
);
    localparam int TERM_MAX = QTR_BASE * 4;
    localparam int CW = $clog2(TERM_MAX + 1);

    logic [CW-1:0] term;
    logic [CW-1:0] cnt;
    logic          at_end;

    always_comb begin
        term   = CW'(QTR_BASE * (1 << tari_shift(tari_code)));
        at_end = (cnt == term - CW'(1));
        tick   = run && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/pie_crc_unit.sv
module pie_crc_unit
    import pie_enc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        shift,
    input  logic        bit_in,
    input  logic        sel16,
    output logic [15:0] crc_word
);
    logic [4:0]  c5;
    logic [15:0] c16;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            c5  <= CRC5_PRESET;
            c16 <= CRC16_PRESET;
        end else if (shift) begin
            c5  <= crc5_next(c5, bit_in);
            c16 <= crc16_next(c16, bit_in);
        end
    end

    // word to append, right-aligned; the 16-bit form goes out complemented
    always_comb begin
        crc_word = sel16 ? ~c16 : {11'b0, c5};
    end
endmodule

// File: rtl/pie_frame_seq.sv
module pie_frame_seq
    import pie_enc_pkg::*;
#(
    parameter int MAX_CMD_BITS = 64,
    parameter int LEN_W = 7,
    parameter int TRCAL_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [MAX_CMD_BITS-1:0] cmd_bits,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic                    crc_sel,
    input  logic                    hdr_sel,
    input  logic [1:0]              tari_sel,
    input  logic [TRCAL_W-1:0]      trcal_hi,
    input  logic                    tick,
    input  logic [15:0]             crc_word,
    output logic                    busy,
    output logic                    accept,
    output logic [1:0]              tari_q,
    output logic                    crc16_q,
    output logic                    crc_shift,
    output logic                    crc_bit,
    output logic                    tx_sample,
    output logic                    tx_valid,
    output logic                    tx_done
);
    localparam int SYM_MAX = ((1 << TRCAL_W) + 1 > 12) ? (1 << TRCAL_W) + 1 : 12;
    localparam int POS_W = $clog2(SYM_MAX + 1);
    localparam int IDX_W = (LEN_W > 5) ? LEN_W : 5;

    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic               crc16;
        logic               pre;
        logic [1:0]         tari;
        logic [TRCAL_W-1:0] trcal;
    } cfg_t;

    cfg_t                    cfg;
    seg_e                    seg;
    logic [POS_W-1:0]        pos;
    logic [IDX_W-1:0]        idx;
    logic [MAX_CMD_BITS-1:0] cmd_sr;
    logic [15:0]             crc_sr;

    logic [LEN_W-1:0] len_eff;
    logic [POS_W-1:0] hi_n;
    logic [POS_W-1:0] lo_n;
    logic             sym_last;
    logic [15:0]      crc_al;
    logic [IDX_W-1:0] cmd_last;
    logic [IDX_W-1:0] crc_last;
    seg_e             pay_seg;

    always_comb begin
        accept  = start && !busy;
        len_eff = (cmd_len > LEN_W'(MAX_CMD_BITS)) ? LEN_W'(MAX_CMD_BITS) : cmd_len;
        crc_al  = cfg.crc16 ? crc_word : {crc_word[4:0], 11'b0};
        cmd_last = IDX_W'(cfg.len) - IDX_W'(1);
        crc_last = cfg.crc16 ? IDX_W'(CRC16_LEN - 1) : IDX_W'(CRC5_LEN - 1);
        pay_seg = (cfg.len != '0) ? SEG_CMD : SEG_CRC;

        hi_n = '0;
        lo_n = POS_W'(SYM_LO_SAMPLES);
        case (seg)
            SEG_DELIM: lo_n = POS_W'(delim_samples(cfg.tari));
            SEG_SYNC0: hi_n = POS_W'(ZERO_HI_SAMPLES);
            SEG_RTCAL: hi_n = POS_W'(RTCAL_HI_SAMPLES);
            SEG_TRCAL: hi_n = POS_W'(cfg.trcal);
            SEG_CMD:   hi_n = cmd_sr[MAX_CMD_BITS-1] ? POS_W'(ONE_HI_SAMPLES) : POS_W'(ZERO_HI_SAMPLES);
            SEG_CRC:   hi_n = crc_sr[15] ? POS_W'(ONE_HI_SAMPLES) : POS_W'(ZERO_HI_SAMPLES);
            default:   lo_n = '0;
        endcase
        sym_last = (pos == hi_n + lo_n - POS_W'(1));

        tari_q    = cfg.tari;
        crc16_q   = cfg.crc16;
        crc_shift = busy && tick && (seg == SEG_CMD) && (pos == '0);
        crc_bit   = cmd_sr[MAX_CMD_BITS-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            seg       <= SEG_DELIM;
            pos       <= '0;
            idx       <= '0;
            cfg       <= '0;
            cmd_sr    <= '0;
            crc_sr    <= '0;
            tx_sample <= 1'b1;
            tx_valid  <= 1'b0;
            tx_done   <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_done  <= 1'b0;
            if (accept) begin
                busy      <= 1'b1;
                seg       <= SEG_DELIM;
                pos       <= '0;
                idx       <= '0;
                cfg.len   <= len_eff;
                cfg.crc16 <= crc_sel;
                cfg.pre   <= hdr_sel;
                cfg.tari  <= tari_sel;
                cfg.trcal <= trcal_hi;
                cmd_sr    <= cmd_bits << (MAX_CMD_BITS - int'(len_eff));
            end else if (busy && tick) begin
                if (seg == SEG_TAIL) begin
                    tx_sample <= 1'b1;
                    tx_done   <= 1'b1;
                    busy      <= 1'b0;
                end else begin
                    tx_sample <= (pos < hi_n);
                    tx_valid  <= 1'b1;
                    if (!sym_last) begin
                        pos <= pos + POS_W'(1);
                    end else begin
                        pos <= '0;
                        case (seg)
                            SEG_DELIM: seg <= SEG_SYNC0;
                            SEG_SYNC0: seg <= SEG_RTCAL;
                            SEG_RTCAL: begin
                                if (cfg.pre) begin
                                    seg <= SEG_TRCAL;
                                end else begin
                                    seg <= pay_seg;
                                    if (cfg.len == '0) crc_sr <= crc_al;
                                end
                            end
                            SEG_TRCAL: begin
                                seg <= pay_seg;
                                if (cfg.len == '0) crc_sr <= crc_al;
                            end
                            SEG_CMD: begin
                                cmd_sr <= cmd_sr << 1;
                                if (idx == cmd_last) begin
                                    seg    <= SEG_CRC;
                                    idx    <= '0;
                                    crc_sr <= crc_al;
                                end else begin
                                    idx <= idx + IDX_W'(1);
                                end
                            end
                            SEG_CRC: begin
                                crc_sr <= crc_sr << 1;
                                if (idx == crc_last) begin
                                    seg <= SEG_TAIL;
                                end else begin
                                    idx <= idx + IDX_W'(1);
                                end
                            end
                            default: seg <= SEG_TAIL;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pie_frame_encoder.sv
module pie_frame_encoder
    import pie_enc_pkg::*;
#(
    parameter int MAX_CMD_BITS = 64,
    parameter int QTR_BASE = 50,
    parameter int TRCAL_W = 6,
    localparam int LEN_W = $clog2(MAX_CMD_BITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [MAX_CMD_BITS-1:0] cmd_bits,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic                    crc_sel,
    input  logic                    hdr_sel,
    input  logic [1:0]              tari_sel,
    input  logic [TRCAL_W-1:0]      trcal_hi,
    input  logic                    start,
    output logic                    tx_sample,
    output logic                    tx_valid,
    output logic                    tx_done
);
    logic        busy;
    logic        accept;
    logic        qtick;
    logic [1:0]  tari_q;
    logic        crc16_q;
    logic        crc_shift;
    logic        crc_bit;
    logic [15:0] crc_word;

    pie_qtick_div #(
        .QTR_BASE(QTR_BASE)
    ) u_div (
        .clk(clk),
        .rst(rst),
        .run(busy),
        .restart(accept),
        .tari_code(tari_q),
        .tick(qtick)
    );

    pie_crc_unit u_crc (
        .clk(clk),
        .rst(rst),
        .init(accept),
        .shift(crc_shift),
        .bit_in(crc_bit),
        .sel16(crc16_q),
        .crc_word(crc_word)
    );

    pie_frame_seq #(
        .MAX_CMD_BITS(MAX_CMD_BITS),
        .LEN_W(LEN_W),
        .TRCAL_W(TRCAL_W)
    ) u_seq (
        .clk(clk),
        .rst(rst),
        .start(start),
        .cmd_bits(cmd_bits),
        .cmd_len(cmd_len),
        .crc_sel(crc_sel),
        .hdr_sel(hdr_sel),
        .tari_sel(tari_sel),
        .trcal_hi(trcal_hi),
        .tick(qtick),
        .crc_word(crc_word),
        .busy(busy),
        .accept(accept),
        .tari_q(tari_q),
        .crc16_q(crc16_q),
        .crc_shift(crc_shift),
        .crc_bit(crc_bit),
        .tx_sample(tx_sample),
        .tx_valid(tx_valid),
        .tx_done(tx_done)
    );
endmodule

// File: rtl/pie_frame_encoder_chk.sv
module pie_frame_encoder_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic qtick,
    input logic tx_sample,
    input logic tx_valid,
    input logic tx_done
);
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(qtick)); // R2

    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy); // R2

    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !tx_valid) |-> $stable(tx_sample)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done); // R9

    AST_DONE_CARRIER: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (tx_sample && !busy && !tx_valid)); // R9

    AST_IDLE_CARRIER: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_sample); // R10

    AST_FRAME_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R11
endmodule

bind pie_frame_encoder pie_frame_encoder_chk u_chk (
    .clk(clk),
    .rst(rst),
    .start(start),
    .busy(busy),
    .qtick(qtick),
    .tx_sample(tx_sample),
    .tx_valid(tx_valid),
    .tx_done(tx_done)
);

// File: tb/pie_frame_encoder_bench.sv
module pie_frame_encoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 64;
    localparam int QB = 3;
    localparam int TW = 6;
    localparam int LW = $clog2(MAXB + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [MAXB-1:0] cmd_bits = '0;
    logic [LW-1:0]   cmd_len = '0;
    logic            crc_sel = 1'b0;
    logic            hdr_sel = 1'b0;
    logic [1:0]      tari_sel = 2'd0;
    logic [TW-1:0]   trcal_hi = '0;
    logic            start = 1'b0;
    logic            tx_sample;
    logic            tx_valid;
    logic            tx_done;

    int vectors = 0;
    int misses = 0;

    bit    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pie_frame_encoder #(
        .MAX_CMD_BITS(MAXB),
        .QTR_BASE(QB),
        .TRCAL_W(TW)
    ) u_pie_frame_encoder (
        .clk(clk),
        .rst(rst),
        .cmd_bits(cmd_bits),
        .cmd_len(cmd_len),
        .crc_sel(crc_sel),
        .hdr_sel(hdr_sel),
        .tari_sel(tari_sel),
        .trcal_hi(trcal_hi),
        .start(start),
        .tx_sample(tx_sample),
        .tx_valid(tx_valid),
        .tx_done(tx_done)
    );

    task automatic compare(input string tag, input bit es, input bit ev, input bit ed);
        vectors++;
        if (tx_sample !== es || tx_valid !== ev || tx_done !== ed) begin
            misses++;
            $display("FAIL %s at %0t: sample/valid/done actual=%b%b%b expected=%b%b%b",
                     tag, $time, tx_sample, tx_valid, tx_done, es, ev, ed);
        end
    endtask

    task automatic push_sym(input int hi, input int lo, input string tag);
        for (int i = 0; i < hi; i++) begin exp_q.push_back(1'b1); tag_q.push_back(tag); end
        for (int i = 0; i < lo; i++) begin exp_q.push_back(1'b0); tag_q.push_back(tag); end
    endtask

    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare("R10", 1'b1, 1'b0, 1'b0);
        end
    endtask

    // build the expected sample list, launch, and compare every cycle
    task automatic run_frame(input logic [MAXB-1:0] cmd, input int len, input bit c16,
                             input bit pre, input int tari, input int trcal,
                             input string ovr, input bit poke);
        int len_eff;
        int term;
        int n;
        int crc;
        bit data[$];
        bit es;
        exp_q.delete();
        tag_q.delete();
        len_eff = (len > MAXB) ? MAXB : len;
        term = QB * ((tari == 0) ? 1 : (tari == 1) ? 2 : 4);
        push_sym(0, (tari == 0) ? 8 : (tari == 1) ? 4 : 2, "R3");
        push_sym(2, 2, "R7");
        push_sym(10, 2, "R7");
        if (pre) push_sym(trcal, 2, "R8");
        for (int i = len_eff - 1; i >= 0; i--) begin
            data.push_back(cmd[i]);
            push_sym(cmd[i] ? 6 : 2, 2, (ovr != "") ? ovr : "R4");
        end
        if (c16) begin
            crc = 'hFFFF;
            foreach (data[i]) begin
                crc = ((crc << 1) & 'hFFFF) ^ ((((crc >> 15) & 1) ^ data[i]) ? 'h1021 : 0);
            end
            crc = (~crc) & 'hFFFF;
            for (int i = 15; i >= 0; i--)
                push_sym(((crc >> i) & 1) ? 6 : 2, 2, (ovr != "") ? ovr : "R6");
        end else begin
            crc = 'b01001;
            foreach (data[i]) begin
                crc = ((crc << 1) & 'h1F) ^ ((((crc >> 4) & 1) ^ data[i]) ? 'b01001 : 0);
            end
            for (int i = 4; i >= 0; i--)
                push_sym(((crc >> i) & 1) ? 6 : 2, 2, (ovr != "") ? ovr : "R5");
        end
        n = exp_q.size();

        @(negedge clk);
        cmd_bits = cmd;
        cmd_len  = LW'(len);
        crc_sel  = c16;
        hdr_sel  = pre;
        tari_sel = 2'(tari);
        trcal_hi = TW'(trcal);
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        compare("R2", 1'b1, 1'b0, 1'b0);
        es = 1'b1;
        for (int j = 1; j <= term * (n + 1); j++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && j == term * 3 + 1) begin
                start    = 1'b1;
                cmd_bits = ~cmd;
                cmd_len  = LW'(3);
                crc_sel  = ~c16;
                hdr_sel  = ~pre;
                tari_sel = 2'(tari ^ 1);
                trcal_hi = TW'(trcal + 7);
            end else if (poke && j == term * 3 + 2) begin
                start = 1'b0;
            end
            if (j % term == 0 && j / term <= n) begin
                es = exp_q[j / term - 1];
                compare((poke) ? "R11" : tag_q[j / term - 1], es, 1'b1, 1'b0);
            end else if (j == term * (n + 1)) begin
                compare("R9", 1'b1, 1'b0, 1'b1);
            end else begin
                compare("R2", es, 1'b0, 1'b0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        misses++;
        $display("FAIL R2 watchdog: actual=still running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1", 1'b1, 1'b0, 1'b0);
        rst = 1'b0;
        idle_check(4);
        // R4 R5 R7: short header, 5-bit checksum, shortest period
        run_frame(64'hA3, 8, 1'b0, 1'b0, 0, 20, "", 1'b0);
        idle_check(5);
        // R6 R8: long header, 16-bit checksum, double period
        run_frame(64'h2D_5A3C, 22, 1'b1, 1'b1, 1, 33, "", 1'b0);
        idle_check(3);
        // R3 R8: quadruple period, short command
        run_frame(64'h9, 4, 1'b0, 1'b1, 2, 12, "", 1'b0);
        // code 3 behaves as code 2
        run_frame(64'hBEEF, 16, 1'b1, 1'b0, 3, 5, "", 1'b0);
        // R12: empty commands, then an over-long length clamped to the maximum
        run_frame(64'h0, 0, 1'b1, 1'b1, 0, 9, "R12", 1'b0);
        run_frame(64'hFFFF, 0, 1'b0, 1'b0, 1, 9, "R12", 1'b0);
        run_frame(64'hC3A5_0F96_1E2D_7B48, 100, 1'b0, 1'b0, 0, 4, "R12", 1'b0);
        // R11: start and input changes while a frame runs
        run_frame(64'h1_6B, 9, 1'b1, 1'b1, 0, 17, "R11", 1'b1);
        idle_check(6);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule